// File: doc/BRIEF.md
# Output Sequencer with Normalizing Shifter

This block gathers finished results from a row of sixteen processing elements and delivers them, one per clock, to a single image-memory write port. Each element shows a 32-bit result, the image-memory address where that result belongs, and a ready flag. The sequencer picks one ready element per cycle in rotating order. It passes the selected result through a barrel shifter that removes a scaling factor or normalizes the value. It then writes the shifted word to the element's address. In the same cycle it pulses an acknowledge back to that element, and the element then withdraws its ready flag.

The shift is set by a small configuration register. That register holds a shift distance of 0 to 31 and a mode bit. The mode bit chooses between a sign-extending right shift, for two's-complement results, and a zero-filling right shift. Memory and the processing elements lie outside the block.

Top module: `pe_result_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_we` is 0 and `src_ack` is all zeros. The first grant after reset searches from source 0 upward, and the configuration register resets to distance 0 in arithmetic mode.
- R2: Only a source whose `src_valid` bit is 1 can be written. When no bit of `src_valid` is 1, no write occurs and the rotation pointer keeps its value.
- R3: A grant goes to the first ready source found when searching upward, with wrap-around, from the index after the last source served.
- R4: A source that is ready at a clock edge and wins the grant there has its write (`mem_we` = 1) visible in the cycle after that edge. With several sources ready, writes follow on consecutive cycles with no idle cycle between them.
- R5: `src_ack` has at most one bit set. It is set for exactly one cycle, in the same cycle as the write, and the set bit is the index of the source being written.
- R6: `mem_addr` equals the 16-bit address of the written source, taken from bits [16*i+15:16*i] of `src_addr`. `mem_wdata` comes from bits [32*i+31:32*i] of `src_data`.
- R7: With `cfg_mode` = 0 (arithmetic), `mem_wdata` is the source word shifted right by the configured distance, with copies of bit 31 filling in from the top. Distances 0 and 31 are included.
- R8: With `cfg_mode` = 1 (logical), `mem_wdata` is the source word shifted right by the configured distance, with zeros filling in from the top.
- R9: A clock edge with `cfg_load` = 1 stores `cfg_shamt` and `cfg_mode`. The stored setting applies to every grant from the next edge on, and `cfg_shamt` and `cfg_mode` have no effect while `cfg_load` is 0.
- R10: A source whose acknowledge is high in the current cycle is not granted again at the following edge, even if its ready bit is still 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Store the shift setting at this edge |
| cfg_shamt | input | 5 | Right-shift distance to store |
| cfg_mode | input | 1 | 0 = arithmetic (sign fill), 1 = logical (zero fill) |
| src_valid | input | 16 | Ready flag per source |
| src_data | input | 512 | Result words, source i in bits [32i+31:32i] |
| src_addr | input | 256 | Target addresses, source i in bits [16i+15:16i] |
| src_ack | output | 16 | One-cycle delivery acknowledge per source |
| mem_we | output | 1 | Image-memory write enable |
| mem_addr | output | 16 | Image-memory write address |
| mem_wdata | output | 32 | Shifted result word |

## Verification
The rotation is tested in three ways. All sixteen sources are raised together, which gives the full ascending order and shows there are no gap cycles. Sparse groups placed on both sides of the last-served index show the wrap-around point. An idle stretch before a new request shows whether the pointer drifted. The shifter gets negative and positive words in both modes, at distances 0, 4 and 31, so that sign fill and zero fill give different results. One source keeps its ready flag high through its acknowledge cycle, which shows whether the arbiter masks a duplicate grant.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

    // Fill policy of the normalizing right shift
    typedef enum logic {
        SHR_ARITH = 1'b0,
        SHR_LOGIC = 1'b1
    } shr_mode_e;

    localparam int unsigned SRC_COUNT_DEF = 16;
    localparam int unsigned WORD_W_DEF    = 32;
    localparam int unsigned ADDR_W_DEF    = 16;

    // Wrap-around index addition used by the rotating search
    function automatic int unsigned wrap_add(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned modulus);
        return (base + off) % modulus;
    endfunction

endpackage

// File: rtl/pe_seq_rr_arbiter.sv
module pe_seq_rr_arbiter #(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    output logic               gnt_vld,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic [NUM_SRC-1:0] gnt_onehot
);
    import pe_seq_pkg::*;

    // Index of the last source served; search starts one above it
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] cand;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = ptr_q;
        cand    = ptr_q;
        for (int off = 1; off <= int'(NUM_SRC); off++) begin
            cand = IDX_W'(wrap_add(int'(ptr_q), off, NUM_SRC));
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = cand;
            end
        end
    end

    assign gnt_onehot = gnt_vld ? (NUM_SRC'(1) << gnt_idx) : '0;

    // Reset value places the first search at source 0
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= IDX_W'(NUM_SRC - 1);
        end else if (gnt_vld) begin
            ptr_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/pe_seq_src_mux.sv
module pe_seq_src_mux #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned ADDR_W  = 16,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC*WORD_W-1:0] data_flat,
    input  logic [NUM_SRC*ADDR_W-1:0] addr_flat,
    input  logic [IDX_W-1:0]          sel,
    output logic [WORD_W-1:0]         data_out,
    output logic [ADDR_W-1:0]         addr_out
);
    logic [WORD_W-1:0] data_arr [NUM_SRC];
    logic [ADDR_W-1:0] addr_arr [NUM_SRC];

    for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_unpack
        assign data_arr[i] = data_flat[i*WORD_W +: WORD_W];
        assign addr_arr[i] = addr_flat[i*ADDR_W +: ADDR_W];
    end

    assign data_out = data_arr[sel];
    assign addr_out = addr_arr[sel];

endmodule

// File: rtl/pe_seq_norm_shifter.sv
module pe_seq_norm_shifter #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned SH_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0]     din,
    input  logic [SH_W-1:0]       amt,
    input  pe_seq_pkg::shr_mode_e mode,
    output logic [WORD_W-1:0]     dout
);
    import pe_seq_pkg::*;

    logic              fill;
    logic [WORD_W-1:0] stage [SH_W+1];

    assign fill     = (mode == SHR_LOGIC) ? 1'b0 : din[WORD_W-1];
    assign stage[0] = din;

    // Logarithmic barrel: stage k moves the word by 2**k when amt[k] is set
    for (genvar k = 0; k < int'(SH_W); k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? { {STEP{fill}}, stage[k][WORD_W-1:STEP] }
            : stage[k];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/pe_result_sequencer.sv
module pe_result_sequencer #(
    parameter int unsigned NUM_SRC = pe_seq_pkg::SRC_COUNT_DEF,
    parameter int unsigned WORD_W  = pe_seq_pkg::WORD_W_DEF,
    parameter int unsigned ADDR_W  = pe_seq_pkg::ADDR_W_DEF,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC),
    localparam int unsigned SH_W   = $clog2(WORD_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_load,
    input  logic [SH_W-1:0]           cfg_shamt,
    input  logic                      cfg_mode,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC*WORD_W-1:0] src_data,
    input  logic [NUM_SRC*ADDR_W-1:0] src_addr,
    output logic [NUM_SRC-1:0]        src_ack,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [WORD_W-1:0]         mem_wdata
);
    import pe_seq_pkg::*;

    typedef struct packed {
        shr_mode_e       mode;
        logic [SH_W-1:0] amt;
    } shift_cfg_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_beat_t;

    shift_cfg_t         cfg_q;
    wr_beat_t           beat_q;
    logic [NUM_SRC-1:0] ack_q;

    logic [NUM_SRC-1:0] req_eff;
    logic               gnt_vld;
    logic [IDX_W-1:0]   gnt_idx;
    logic [NUM_SRC-1:0] gnt_onehot;
    logic [WORD_W-1:0]  sel_data;
    logic [ADDR_W-1:0]  sel_addr;
    logic [WORD_W-1:0]  shifted;

    // Configuration register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: SHR_ARITH, amt: '0};
        end else if (cfg_load) begin
            cfg_q <= '{mode: shr_mode_e'(cfg_mode), amt: cfg_shamt};
        end
    end

    // A source being acknowledged this cycle may not have dropped ready yet
    assign req_eff = src_valid & ~ack_q;

    pe_seq_rr_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (req_eff),
        .gnt_vld    (gnt_vld),
        .gnt_idx    (gnt_idx),
        .gnt_onehot (gnt_onehot)
    );

    pe_seq_src_mux #(
        .NUM_SRC (NUM_SRC),
        .WORD_W  (WORD_W),
        .ADDR_W  (ADDR_W)
    ) u_mux (
        .data_flat (src_data),
        .addr_flat (src_addr),
        .sel       (gnt_idx),
        .data_out  (sel_data),
        .addr_out  (sel_addr)
    );

    pe_seq_norm_shifter #(.WORD_W(WORD_W)) u_shr (
        .din  (sel_data),
        .amt  (cfg_q.amt),
        .mode (cfg_q.mode),
        .dout (shifted)
    );

    // Output stage: write beat and acknowledge launch together
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            ack_q  <= '0;
        end else begin
            beat_q.we <= gnt_vld;
            ack_q     <= gnt_onehot;
            if (gnt_vld) begin
                beat_q.addr <= sel_addr;
                beat_q.data <= shifted;
            end
        end
    end

    assign src_ack   = ack_q;
    assign mem_we    = beat_q.we;
    assign mem_addr  = beat_q.addr;
    assign mem_wdata = beat_q.data;

endmodule

// File: rtl/pe_result_sequencer_chk.sv
module pe_result_sequencer_chk #(
    parameter int unsigned NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_valid,
    input logic [NUM_SRC-1:0] src_ack,
    input logic               mem_we
);
    // R5
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ack));

    // R5
    ack_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_ack) == mem_we);

    // R10
    ack_not_repeated_chk: assert property (@(posedge clk) disable iff (rst)
        (src_ack & $past(src_ack)) == '0);

    // R2
    grant_was_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (($past(src_valid) & src_ack) != '0));

    // R2
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (src_valid == '0) |=> !mem_we);

endmodule

bind pe_result_sequencer pe_result_sequencer_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .src_ack   (src_ack),
    .mem_we    (mem_we)
);

// File: tb/sim_pe_result_sequencer.sv
module sim_pe_result_sequencer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_load = 1'b0;
    logic [4:0]   cfg_shamt = '0;
    logic         cfg_mode = 1'b0;
    logic [15:0]  rdy = '0;
    logic [511:0] src_data;
    logic [255:0] src_addr;
    logic [15:0]  src_ack;
    logic         mem_we;
    logic [15:0]  mem_addr;
    logic [31:0]  mem_wdata;

    logic [31:0]  d_m [16];
    logic [15:0]  a_m [16];

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q [$];
    logic [4:0] m_amt = '0;
    logic       m_logic = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            src_data[i*32 +: 32] = d_m[i];
            src_addr[i*16 +: 16] = a_m[i];
        end
    end

    pe_result_sequencer u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_shamt (cfg_shamt),
        .cfg_mode  (cfg_mode),
        .src_valid (rdy),
        .src_data  (src_data),
        .src_addr  (src_addr),
        .src_ack   (src_ack),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    function automatic logic [31:0] norm(input logic [31:0] d);
        if (m_logic) return d >> m_amt;
        return 32'($signed(d) >>> m_amt);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [4:0] a, input logic m);
        @(negedge clk);
        cfg_load = 1'b1; cfg_shamt = a; cfg_mode = m;
        @(negedge clk);
        cfg_load = 1'b0; cfg_shamt = ~a; cfg_mode = ~m;
        m_amt = a; m_logic = m;
    endtask

    // Observes one write per expected source, releasing each on its ack
    task automatic drain(input string dtag, output int gaps);
        bit started = 0;
        int guard = 0;
        gaps = 0;
        while (exp_q.size() > 0 && guard < 200) begin
            @(negedge clk);
            guard++;
            if (mem_we) begin
                int e = exp_q.pop_front();
                started = 1;
                chk(src_ack == (16'd1 << e), "R5 ack source", 64'(src_ack), 64'(16'd1 << e));
                chk(mem_addr == a_m[e], "R6 address", 64'(mem_addr), 64'(a_m[e]));
                chk(mem_wdata == norm(d_m[e]), dtag, 64'(mem_wdata), 64'(norm(d_m[e])));
                rdy[e] = 1'b0;
            end else begin
                chk(src_ack == '0, "R5 ack without write", 64'(src_ack), 64'h0);
                if (started) gaps++;
            end
        end
        chk(exp_q.size() == 0, "R4 all writes seen", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_we == 1'b0 && src_ack == '0, "R1 outputs in reset", {mem_we, src_ack}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_we == 1'b0 && src_ack == '0, "R1 outputs after reset", {mem_we, src_ack}, 64'h0);
    endtask

    task automatic t_all_sixteen();
        int gaps;
        for (int i = 0; i < 16; i++) begin
            d_m[i] = 32'h8000_0000 | (32'(i) * 32'h0101_0101) | 32'(i);
            a_m[i] = 16'h0100 + 16'(i * 3);
            exp_q.push_back(i);
        end
        @(negedge clk);
        rdy = 16'hFFFF;
        drain("R7 shift zero arithmetic", gaps);
        chk(gaps == 0, "R4 back-to-back writes", 64'(gaps), 64'h0);
    endtask

    task automatic t_latency();
        d_m[4] = 32'h1234_5678; a_m[4] = 16'hBEEF;
        @(negedge clk);
        rdy[4] = 1'b1;
        @(negedge clk);
        chk(mem_we == 1'b1 && src_ack == 16'h0010, "R4 write one cycle after grant",
            {mem_we, src_ack}, {1'b1, 16'h0010});
        rdy[4] = 1'b0;
        @(negedge clk);
        chk(mem_we == 1'b0 && src_ack == '0, "R5 ack single cycle", {mem_we, src_ack}, 64'h0);
    endtask

    task automatic t_idle_then_pair();
        int gaps;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(mem_we == 1'b0, "R2 no write when idle", 64'(mem_we), 64'h0);
        end
        // last served is 4: search from 5 finds 9 before 2
        exp_q.push_back(9); exp_q.push_back(2);
        rdy[2] = 1'b1; rdy[9] = 1'b1;
        drain("R6 data pair", gaps);
    endtask

    task automatic t_rotate();
        int gaps;
        // last served is 2: search from 3
        exp_q.push_back(3); exp_q.push_back(1); exp_q.push_back(2);
        @(negedge clk);
        rdy[1] = 1'b1; rdy[2] = 1'b1; rdy[3] = 1'b1;
        drain("R3 rotation data", gaps);
        chk(gaps == 0, "R3 rotation no gaps", 64'(gaps), 64'h0);
    endtask

    task automatic t_shift_modes();
        int gaps;
        load_cfg(5'd4, 1'b0);
        d_m[6] = 32'hFFFF_F000; d_m[10] = 32'h7000_0010;
        exp_q.push_back(6); exp_q.push_back(10);
        @(negedge clk);
        rdy[6] = 1'b1; rdy[10] = 1'b1;
        drain("R7 arithmetic by 4", gaps);
        chk(norm(32'hFFFF_F000) == 32'hFFFF_FF00, "R7 model sanity",
            64'(norm(32'hFFFF_F000)), 64'hFFFF_FF00);
        load_cfg(5'd4, 1'b1);
        exp_q.push_back(6);
        @(negedge clk);
        rdy[6] = 1'b1;
        drain("R8 logical by 4", gaps);
        load_cfg(5'd31, 1'b0);
        d_m[0] = 32'h8000_0000;
        exp_q.push_back(0);
        @(negedge clk);
        rdy[0] = 1'b1;
        drain("R7 arithmetic by 31", gaps);
        load_cfg(5'd31, 1'b1);
        exp_q.push_back(0);
        @(negedge clk);
        rdy[0] = 1'b1;
        drain("R8 logical by 31", gaps);
        load_cfg(5'd0, 1'b1);
        exp_q.push_back(6);
        @(negedge clk);
        rdy[6] = 1'b1;
        drain("R8 logical by 0", gaps);
    endtask

    task automatic t_cfg_ignored();
        int gaps;
        // R9: inputs move while cfg_load is low; stored setting (0, logical) stays
        @(negedge clk);
        cfg_shamt = 5'd9; cfg_mode = 1'b0;
        d_m[12] = 32'hF000_0000;
        exp_q.push_back(12);
        @(negedge clk);
        rdy[12] = 1'b1;
        drain("R9 config held without load", gaps);
    endtask

    task automatic t_late_drop();
        d_m[7] = 32'h0000_0077; a_m[7] = 16'h0707;
        @(negedge clk);
        rdy[7] = 1'b1;
        @(negedge clk);
        chk(mem_we == 1'b1 && src_ack == 16'h0080, "R10 first write",
            {mem_we, src_ack}, {1'b1, 16'h0080});
        @(negedge clk);
        chk(mem_we == 1'b0, "R10 no regrant during ack", 64'(mem_we), 64'h0);
        rdy[7] = 1'b0;
        @(negedge clk);
        chk(mem_we == 1'b0 && src_ack == '0, "R10 quiet after drop", {mem_we, src_ack}, 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            d_m[i] = '0;
            a_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        t_reset();
        t_all_sixteen();
        t_latency();
        t_idle_then_pair();
        t_rotate();
        t_shift_modes();
        t_cfg_ignored();
        t_late_drop();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule